// File: doc/BRIEF.md
# SPI Register-File Slave with Burst Access

This block lets an external SPI master read and write a small bank of byte registers held inside the chip. Chip select frames each transaction. The first byte the master shifts in is a command: its top bit chooses the direction and its low bits give the start register. Every later byte in the same chip-select window moves one data byte. In a write the byte is stored, and in a read the byte is returned on MISO. The working address then steps forward by one, so a single transaction can cover a run of consecutive registers.

The SPI pins are sampled by the system clock. Each pin passes through a synchroniser and an edge detector, so the serial clock must be several times slower than the system clock. A separate local read port gives the on-chip logic a direct, combinational view of any register.

Top module: `spi_regfile_slave`

## Requirements
- R1: After reset every one of the 64 registers reads 0x00 and MISO is 0.
- R2: The bus uses SPI mode 0 and shifts MSB first. The master drives MOSI while SCLK is low, both sides sample on the SCLK rising edge, and the slave updates MISO after a falling edge. In the command byte, bit 7 = 1 selects a read and bit 7 = 0 selects a write.
- R3: In a write transaction, data byte k after the command is stored at register (start + k) mod 64.
- R4: In a read transaction, data byte k returned on MISO after the command equals register (start + k) mod 64, MSB first, starting with the byte that immediately follows the command.
- R5: During a burst the working address wraps from 0x3F to 0x00.
- R6: Bit 6 of the command byte has no effect. Bits 5:0 alone form the start address.
- R7: If chip select rises while a byte is incomplete, the partial byte is dropped and no register changes.
- R8: MISO is 0 while chip select is inactive, and it is 0 throughout the command byte.
- R9: The local read port returns the current content of the register selected by the local address, with no clock delay.
- R10: Each new chip-select window begins with a command byte, whatever the previous transaction was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock from the master |
| csN | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| locAddr | input | 6 | Local read port register index |
| locData | output | 8 | Local read port data |

## Verification
The hardest situations to reach from the ports sit at frame edges. One is a burst that runs past address 0x3F. Another is chip select rising partway through a byte, just after a complete byte has already been written. The stimulus brings about both with directed frames: writes and reads that start at 0x3E and 0x3F, and a frame cut off after a chosen number of bits. Seeded random frames then mix directions, start addresses, bit-6 values and burst lengths, and every result is compared against a model of the register file kept in the bench.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic clear;    // frame inactive
    logic shiftIn;  // capture one MOSI bit
    logic rxBit;    // synchronised MOSI value
    logic setAddr;  // command byte complete: take start address
    logic incAddr;  // data byte complete: step address
    logic wrReg;    // store received data byte
    logic loadTx;   // fetch register into transmit shifter
    logic shiftTx;  // advance transmit shifter
  } rfStrobe_t;

endpackage

// File: rtl/spi_rf_ctrl.sv
module spi_rf_ctrl
  import spi_rf_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclk,
  input  logic      csN,
  input  logic      mosi,
  input  logic      cmdIsRead,
  output rfStrobe_t strobe
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  typedef enum logic [1:0] {PH_CMD, PH_WRITE, PH_READ} phase_t;

  logic [SYNC_STAGES-1:0] sclkSync, csSync, mosiSync;
  logic                   sclkPrev;
  logic [CNT_W-1:0]       bitCnt;
  phase_t                 phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      csSync   <= '1;
      mosiSync <= '0;
      sclkPrev <= 1'b0;
    end else begin
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], sclk};
      csSync   <= {csSync[SYNC_STAGES-2:0], csN};
      mosiSync <= {mosiSync[SYNC_STAGES-2:0], mosi};
      sclkPrev <= sclkSync[SYNC_STAGES-1];
    end
  end

  logic sclkNow, sclkRise, sclkFall, active, lastBit;
  assign sclkNow  = sclkSync[SYNC_STAGES-1];
  assign sclkRise = sclkNow & ~sclkPrev;
  assign sclkFall = ~sclkNow & sclkPrev;
  assign active   = ~csSync[SYNC_STAGES-1];
  assign lastBit  = (bitCnt == LAST_BIT);

  always_comb begin
    strobe       = '0;
    strobe.clear = ~active;
    strobe.rxBit = mosiSync[SYNC_STAGES-1];
    if (active && sclkRise) begin
      strobe.shiftIn = 1'b1;
      if (lastBit) begin
        unique case (phase)
          PH_CMD: begin
            strobe.setAddr = 1'b1;
            strobe.loadTx  = cmdIsRead;
          end
          PH_WRITE: begin
            strobe.wrReg   = 1'b1;
            strobe.incAddr = 1'b1;
          end
          default: begin
            strobe.incAddr = 1'b1;
            strobe.loadTx  = 1'b1;
          end
        endcase
      end
    end
    // first falling edge after a byte boundary keeps the fresh MSB on MISO
    if (active && sclkFall && bitCnt != '0) strobe.shiftTx = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      phase  <= PH_CMD;
    end else if (!active) begin
      bitCnt <= '0;          // R7: partial byte dropped
      phase  <= PH_CMD;      // R10
    end else if (sclkRise) begin
      bitCnt <= lastBit ? '0 : bitCnt + CNT_W'(1);
      if (lastBit && phase == PH_CMD)
        phase <= cmdIsRead ? PH_READ : PH_WRITE;
    end
  end

  // R2
  cmd_sets_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setAddr |=> phase != PH_CMD);

  // R10
  idle_resets_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (phase == PH_CMD && bitCnt == '0));

endmodule

// File: rtl/spi_rf_datapath.sv
module spi_rf_datapath
  import spi_rf_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rfStrobe_t         strobe,
  input  logic [ADDR_W-1:0] locAddr,
  output logic [DATA_W-1:0] locData,
  output logic              cmdIsRead,
  output logic              miso
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] rxShift, txShift, fullByte;
  logic [ADDR_W-1:0] addr, cmdAddr, fetchAddr;
  logic [DATA_W-1:0] regFile [DEPTH];

  assign fullByte  = {rxShift[DATA_W-2:0], strobe.rxBit};
  assign cmdIsRead = rxShift[DATA_W-2];          // becomes bit 7 of full byte
  assign cmdAddr   = fullByte[ADDR_W-1:0];       // R6: bit 6 unused
  assign fetchAddr = strobe.setAddr ? cmdAddr : addr + ADDR_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      addr    <= '0;
    end else begin
      if (strobe.shiftIn) rxShift <= fullByte;
      if (strobe.setAddr) addr <= cmdAddr;
      else if (strobe.incAddr) addr <= addr + ADDR_W'(1);   // R5 wraps
    end
  end

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : gen_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) regFile[g] <= '0;
        else if (strobe.wrReg && addr == ADDR_W'(g)) regFile[g] <= fullByte;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               txShift <= '0;
    else if (strobe.clear)   txShift <= '0;
    else if (strobe.loadTx)  txShift <= regFile[fetchAddr];
    else if (strobe.shiftTx) txShift <= {txShift[DATA_W-2:0], 1'b0};
  end

  assign miso    = ~strobe.clear & txShift[DATA_W-1];
  assign locData = regFile[locAddr];

  // R3
  write_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrReg |=> regFile[$past(addr)] == $past(fullByte));

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.incAddr && !strobe.setAddr) |=> addr == $past(addr) + ADDR_W'(1));

  // R6
  start_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setAddr |=> addr == $past(fullByte[ADDR_W-1:0]));

  // R8
  idle_tx_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> txShift == '0);

endmodule

// File: rtl/spi_regfile_slave.sv
module spi_regfile_slave
  import spi_rf_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              csN,
  input  logic              mosi,
  output logic              miso,
  input  logic [ADDR_W-1:0] locAddr,
  output logic [DATA_W-1:0] locData
);

  rfStrobe_t strobe;
  logic      cmdIsRead;

  spi_rf_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi),
    .cmdIsRead(cmdIsRead), .strobe(strobe)
  );

  spi_rf_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .locAddr(locAddr),
    .locData(locData), .cmdIsRead(cmdIsRead), .miso(miso)
  );

endmodule

// File: tb/spi_regfile_slave_tb_top.sv
module spi_regfile_slave_tb_top;

  localparam int HALF = 8;   // system clocks per SCLK half period

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclk = 1'b0;
  logic       csN = 1'b1;
  logic       mosi = 1'b0;
  logic       miso;
  logic [5:0] locAddr = '0;
  logic [7:0] locData;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 0;
  logic [7:0] model [64];

  always #2 clk = ~clk;   // 250 MHz

  spi_regfile_slave dut_i (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi),
    .miso(miso), .locAddr(locAddr), .locData(locData)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] wrapAddr(input logic [5:0] a, input int k);
    return 6'((int'(a) + k) % 64);
  endfunction

  task automatic waitHalf();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic xferBits(input logic [7:0] txb, input int nBits, output logic [7:0] rxb);
    rxb = '0;
    for (int i = 7; i >= 8 - nBits; i--) begin
      mosi = txb[i];
      waitHalf();
      rxb[i] = miso;
      sclk = 1'b1;
      waitHalf();
      sclk = 1'b0;
    end
  endtask

  task automatic frameStart();
    csN = 1'b0;
    waitHalf();
  endtask

  task automatic frameEnd();
    waitHalf();
    csN = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic doWrite(input logic [5:0] a, input bit b6, input int n);
    logic [7:0] rxb, d;
    frameStart();
    xferBits({1'b0, b6, a}, 8, rxb);
    chk("R8 miso during command", rxb, 8'h00);
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      xferBits(d, 8, rxb);
      model[wrapAddr(a, k)] = d;
    end
    frameEnd();
  endtask

  task automatic doRead(input logic [5:0] a, input bit b6, input int n);
    logic [7:0] rxb;
    frameStart();
    xferBits({1'b1, b6, a}, 8, rxb);
    chk("R8 miso during command", rxb, 8'h00);
    for (int k = 0; k < n; k++) begin
      xferBits(8'($urandom), 8, rxb);
      if (int'(a) + k >= 64) chk("R5 read wrap", rxb, model[wrapAddr(a, k)]);
      else                   chk("R4 read burst", rxb, model[wrapAddr(a, k)]);
    end
    frameEnd();
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < 64; i++) begin
      locAddr = 6'(i);
      #1;
      chk(req, locData, model[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rxb;
    void'($urandom(32'h5A17));
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset contents and MISO
    sweep("R1 reset contents");
    chk("R1 miso after reset", {7'b0, miso}, 8'h00);

    // R2/R3: simple write burst, MSB first
    doWrite(6'h10, 1'b0, 4);
    for (int k = 0; k < 4; k++) begin
      locAddr = 6'(16 + k);
      #1;
      chk("R3 write burst", locData, model[16 + k]);
    end

    // R4: read back burst right after command
    doRead(6'h10, 1'b0, 4);

    // R5: write wraps from 0x3F to 0x00
    doWrite(6'h3E, 1'b0, 4);
    for (int k = 0; k < 4; k++) begin
      locAddr = wrapAddr(6'h3E, k);
      #1;
      chk("R5 write wrap", locData, model[wrapAddr(6'h3E, k)]);
    end
    doRead(6'h3F, 1'b0, 3);

    // R6: bit 6 set on write and read
    doWrite(6'h05, 1'b1, 2);
    locAddr = 6'h05; #1;
    chk("R6 bit6 ignored on write", locData, model[5]);
    locAddr = 6'h45 & 6'h3F; #1;
    doRead(6'h05, 1'b1, 2);

    // R7: one full byte then a 5-bit partial byte
    frameStart();
    xferBits(8'h20, 8, rxb);           // write command at 0x20
    xferBits(8'hC3, 8, rxb);
    model[32] = 8'hC3;
    xferBits(8'h99, 5, rxb);
    frameEnd();
    locAddr = 6'h21; #1;
    chk("R7 partial byte not written", locData, model[33]);
    locAddr = 6'h20; #1;
    chk("R7 full byte kept", locData, model[32]);
    // R7/R10: a frame cut inside the command byte, next frame still a command
    frameStart();
    xferBits(8'h80, 3, rxb);
    frameEnd();
    doRead(6'h20, 1'b0, 1);

    // R8: MISO idle between frames
    chk("R8 miso idle", {7'b0, miso}, 8'h00);

    // R10 and mixed random frames
    for (int t = 0; t < 30; t++) begin
      logic [5:0] a;
      bit b6, rd;
      int n;
      a  = 6'($urandom);
      b6 = 1'($urandom);
      rd = 1'($urandom);
      n  = 1 + int'($urandom % 8);
      if (rd) doRead(a, b6, n);
      else    doWrite(a, b6, n);
      chk("R8 miso idle after frame", {7'b0, miso}, 8'h00);
    end

    // R9: local port shows every register
    sweep("R9 local read port");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule